// File: doc/BRIEF.md
# Masked Three-Input Bitwise Logic Unit

This block evaluates an arbitrary Boolean function of three wide vector operands, one bit position at a time. An 8-bit truth-table immediate is indexed by the three operand bits found at each position. Because every three-input function has exactly eight rows, any one of the 256 possible functions can be selected by the immediate alone.

A write mask then decides which elements of the result are kept. The mask is applied per 32-bit element, or per 64-bit element when the wide element size is chosen. The element size changes nothing else. A disabled element is either cleared to zero or given the contents of operand A, as the mode flag selects. The masked result is registered, so it appears one clock after the input is accepted. The unit sits behind an instruction decoder that supplies the operands, the immediate and the controls.

Top module: `tri_logic_unit`

## Requirements
- R1: For an enabled element, each result bit k equals `tt_imm[{opd_a[k], opd_b[k], opd_c[k]}]`. Operand A supplies the most significant bit of the 3-bit index and operand C the least significant bit.
- R2: When `elem_wide` = 0 (32-bit elements), result bits [32i+31:32i] are enabled exactly when `wmask[i]` = 1, for i = 0..15.
- R3: When `elem_wide` = 1 (64-bit elements), result bits [64j+63:64j] are enabled exactly when `wmask[j]` = 1, for j = 0..7. Mask bits 15..8 have no effect on the result.
- R4: When `zero_mode` = 1, every bit of a disabled element is 0.
- R5: When `zero_mode` = 0 (merge), a disabled element takes the value of the corresponding bits of `opd_a`.
- R6: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `result` reflects that input one clock edge later and holds its value through cycles without `in_valid`.
- R7: A clock edge with `rst` high sets `out_valid` to 0 and `result` to all zeros.
- R8: With every relevant mask bit set, `result` equals the pure truth-table function of the operands for either element size and either mode.

Ports (the "Width" column for operand ports is `VEC_W` = 512 by default):

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| opd_a | input | 512 | Operand A: index MSB and merge source |
| opd_b | input | 512 | Operand B: middle index bit |
| opd_c | input | 512 | Operand C: index LSB |
| tt_imm | input | 8 | Truth table of the three-input function |
| elem_wide | input | 1 | 0 = 32-bit elements, 1 = 64-bit elements |
| wmask | input | 16 | Per-element write mask |
| zero_mode | input | 1 | 1 = clear disabled elements, 0 = merge from A |
| out_valid | output | 1 | Result register was loaded on the last edge |
| result | output | 512 | Registered masked result |

## Verification
A wrong lane-enable map would leave whole 32-bit or 64-bit slices holding the function value where operand A or zero was expected. It would show on the result bus one edge after the offending input. A misrouted truth-table index appears as flipped bits that follow the operand pattern, even with a full mask. A faulty hold or valid path appears as a result that changes on idle cycles, or as an `out_valid` pulse that is early, late or missing.

// File: rtl/tlu_pkg.sv
package tlu_pkg;
  localparam int unsigned VEC_W_DEF  = 512;
  localparam int unsigned NARROW_W   = 32;
  localparam int unsigned IMM_W      = 8;

  typedef enum logic {
    ELEM_32 = 1'b0,
    ELEM_64 = 1'b1
  } elem_size_e;
endpackage

// File: rtl/tlu_lookup.sv
module tlu_lookup #(
  parameter int unsigned VEC_W = 512
) (
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  input  logic [VEC_W-1:0] c,
  input  logic [7:0]       table_bits,
  output logic [VEC_W-1:0] f
);
  // one 8:1 selector per bit position, index {a,b,c}
  for (genvar k = 0; k < VEC_W; k++) begin : g_bit
    logic [2:0] idx;
    assign idx  = {a[k], b[k], c[k]};
    assign f[k] = table_bits[idx];
  end
endmodule

// File: rtl/tlu_lane_enable.sv
module tlu_lane_enable
  import tlu_pkg::*;
#(
  parameter int unsigned VEC_W  = 512,
  parameter int unsigned LANE_W = 32,
  localparam int unsigned LANES  = VEC_W / LANE_W
) (
  input  logic [LANES-1:0] wmask,
  input  logic             elem_wide,
  output logic [LANES-1:0] lane_en
);
  // narrow lane i pairs with wide element i/2
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int unsigned PAIR = i / 2;
    logic en_narrow, en_wide;
    assign en_narrow  = wmask[i];
    assign en_wide    = wmask[PAIR];
    assign lane_en[i] = (elem_size_e'(elem_wide) == ELEM_64) ? en_wide : en_narrow;
  end
endmodule

// File: rtl/tlu_lane_select.sv
module tlu_lane_select #(
  parameter int unsigned VEC_W  = 512,
  parameter int unsigned LANE_W = 32,
  localparam int unsigned LANES  = VEC_W / LANE_W
) (
  input  logic [VEC_W-1:0] func_val,
  input  logic [VEC_W-1:0] merge_val,
  input  logic [LANES-1:0] lane_en,
  input  logic             zero_mode,
  output logic [VEC_W-1:0] sel_val
);
  for (genvar i = 0; i < LANES; i++) begin : g_sel
    logic [LANE_W-1:0] off_val;
    assign off_val = zero_mode ? '0 : merge_val[i*LANE_W +: LANE_W];
    assign sel_val[i*LANE_W +: LANE_W] =
      lane_en[i] ? func_val[i*LANE_W +: LANE_W] : off_val;
  end
endmodule

// File: rtl/tri_logic_unit.sv
module tri_logic_unit
  import tlu_pkg::*;
#(
  parameter int unsigned VEC_W  = VEC_W_DEF,
  parameter int unsigned LANE_W = NARROW_W,
  localparam int unsigned MASK_W = VEC_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [VEC_W-1:0]  opd_a,
  input  logic [VEC_W-1:0]  opd_b,
  input  logic [VEC_W-1:0]  opd_c,
  input  logic [IMM_W-1:0]  tt_imm,
  input  logic              elem_wide,
  input  logic [MASK_W-1:0] wmask,
  input  logic              zero_mode,
  output logic              out_valid,
  output logic [VEC_W-1:0]  result
);
  logic [VEC_W-1:0]  func_val;
  logic [VEC_W-1:0]  sel_val;
  logic [MASK_W-1:0] lane_en;
  logic [VEC_W-1:0]  result_q;
  logic              valid_q;

  tlu_lookup #(.VEC_W(VEC_W)) u_lookup (
    .a(opd_a), .b(opd_b), .c(opd_c), .table_bits(tt_imm), .f(func_val)
  );

  tlu_lane_enable #(.VEC_W(VEC_W), .LANE_W(LANE_W)) u_enable (
    .wmask(wmask), .elem_wide(elem_wide), .lane_en(lane_en)
  );

  tlu_lane_select #(.VEC_W(VEC_W), .LANE_W(LANE_W)) u_select (
    .func_val(func_val), .merge_val(opd_a), .lane_en(lane_en),
    .zero_mode(zero_mode), .sel_val(sel_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      result_q <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) result_q <= sel_val;
    end
  end

  assign out_valid = valid_q;
  assign result    = result_q;
endmodule

// File: rtl/tri_logic_unit_chk.sv
module tri_logic_unit_chk #(
  parameter int unsigned VEC_W  = 512,
  parameter int unsigned MASK_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [VEC_W-1:0]  opd_a,
  input logic [VEC_W-1:0]  opd_b,
  input logic [VEC_W-1:0]  opd_c,
  input logic [7:0]        tt_imm,
  input logic              elem_wide,
  input logic [MASK_W-1:0] wmask,
  input logic              zero_mode,
  input logic              out_valid,
  input logic [VEC_W-1:0]  result
);
  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> $stable(result));

  assert_reset_clears_R7: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && result == '0));

  assert_zero_all_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid && zero_mode && wmask == '0)) |-> (result == '0));

  assert_merge_all_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid && !zero_mode && wmask == '0)) |-> (result == $past(opd_a)));

  assert_bit0_lookup_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid && wmask[0])) |->
      (result[0] == $past(tt_imm[{opd_a[0], opd_b[0], opd_c[0]}])));

  assert_wide_upper_half_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid && elem_wide && wmask[0])) |->
      (result[32] == $past(tt_imm[{opd_a[32], opd_b[32], opd_c[32]}])));
endmodule

bind tri_logic_unit tri_logic_unit_chk #(.VEC_W(VEC_W), .MASK_W(MASK_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .opd_a(opd_a), .opd_b(opd_b),
  .opd_c(opd_c), .tt_imm(tt_imm), .elem_wide(elem_wide), .wmask(wmask),
  .zero_mode(zero_mode), .out_valid(out_valid), .result(result)
);

// File: tb/tri_logic_unit_bench.sv
module tri_logic_unit_bench;
  localparam int VW = 512;
  localparam int MW = 16;
  localparam int NV = 10;

  // {seed[7:0], imm[7:0], wide, zero, mask[15:0]}
  localparam logic [33:0] TBL [0:NV-1] = '{
    {8'h11, 8'h96, 1'b0, 1'b0, 16'hFFFF},
    {8'h22, 8'hE8, 1'b0, 1'b1, 16'hA5A5},
    {8'h33, 8'hCA, 1'b0, 1'b0, 16'h0F0F},
    {8'h44, 8'h00, 1'b0, 1'b0, 16'h0000},
    {8'h55, 8'hFF, 1'b1, 1'b1, 16'h0055},
    {8'h66, 8'h80, 1'b1, 1'b0, 16'hFF00},
    {8'h77, 8'hFE, 1'b1, 1'b1, 16'hFFAA},
    {8'h88, 8'hF0, 1'b0, 1'b1, 16'h1234},
    {8'h99, 8'h3C, 1'b1, 1'b0, 16'h00FF},
    {8'hAA, 8'h01, 1'b0, 1'b1, 16'h8001}
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [VW-1:0] opd_a, opd_b, opd_c;
  logic [7:0]    tt_imm;
  logic          elem_wide;
  logic [MW-1:0] wmask;
  logic          zero_mode;
  logic          out_valid;
  logic [VW-1:0] result;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  tri_logic_unit u_tri_logic_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opd_a(opd_a), .opd_b(opd_b),
    .opd_c(opd_c), .tt_imm(tt_imm), .elem_wide(elem_wide), .wmask(wmask),
    .zero_mode(zero_mode), .out_valid(out_valid), .result(result)
  );

  function automatic logic [VW-1:0] gen(input logic [31:0] seed);
    logic [VW-1:0] v;
    logic [31:0] x;
    x = seed * 32'h9E3779B9 + 32'h7F4A7C15;
    for (int i = 0; i < VW / 32; i++) begin
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      v[i*32 +: 32] = x;
    end
    return v;
  endfunction

  // expected value taken from the requirements
  function automatic logic [VW-1:0] model(
    input logic [VW-1:0] a, input logic [VW-1:0] b, input logic [VW-1:0] c,
    input logic [7:0] imm, input logic wide, input logic [MW-1:0] m, input logic z);
    logic [VW-1:0] r;
    for (int k = 0; k < VW; k++) begin
      logic fv, en;
      fv = imm[{a[k], b[k], c[k]}];
      en = wide ? m[k / 64] : m[k / 32];
      r[k] = en ? fv : (z ? 1'b0 : a[k]);
    end
    return r;
  endfunction

  task automatic chk_vec(input string rq, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s result act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic chk_bit(input string rq, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s out_valid act=%b exp=%b", rq, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] seed, input logic [7:0] imm,
                       input logic wide, input logic z, input logic [MW-1:0] m);
    opd_a = gen(seed); opd_b = gen(seed + 101); opd_c = gen(seed + 202);
    tt_imm = imm; elem_wide = wide; zero_mode = z; wmask = m;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] exp_v;
    rst = 1'b1; in_valid = 1'b0;
    drive(32'd5, 8'h96, 1'b0, 1'b0, 16'hFFFF);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_bit("R7 reset", out_valid, 1'b0);
    chk_vec("R7 reset", result, '0);
    rst = 1'b0;

    // table walk: R1 R2 R3 R4 R5 R8 by entry
    for (int e = 0; e < NV; e++) begin
      logic [33:0] t;
      t = TBL[e];
      drive({24'd0, t[33:26]}, t[25:18], t[17], t[16], t[15:0]);
      exp_v = model(opd_a, opd_b, opd_c, tt_imm, elem_wide, wmask, zero_mode);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk_bit("R6 valid", out_valid, 1'b1);
      chk_vec(t[17] ? (t[16] ? "R1 R3 R4 R8" : "R1 R3 R5 R8")
                    : (t[16] ? "R1 R2 R4 R8" : "R1 R2 R5 R8"), result, exp_v);
    end

    // R6: idle cycle drops out_valid and holds result despite new inputs
    drive(32'd999, 8'h5A, 1'b1, 1'b1, 16'h0000);
    @(negedge clk);
    chk_bit("R6 idle", out_valid, 1'b0);
    chk_vec("R6 hold", result, exp_v);

    // R3: upper mask bits ignored in wide mode
    drive(32'd321, 8'h69, 1'b1, 1'b1, 16'hFF3C);
    exp_v = model(opd_a, opd_b, opd_c, 8'h69, 1'b1, 16'h003C, 1'b1);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk_vec("R3 upper mask ignored", result, exp_v);

    // R8: full mask, both modes give the pure function
    drive(32'd77, 8'hD8, 1'b0, 1'b1, 16'hFFFF);
    exp_v = model(opd_a, opd_b, opd_c, 8'hD8, 1'b0, 16'hFFFF, 1'b0);
    in_valid = 1'b1;
    @(negedge clk);
    chk_vec("R8 full mask zero", result, exp_v);
    zero_mode = 1'b0; elem_wide = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk_vec("R8 full mask merge", result, exp_v);

    // R1: single-bit index ordering, A is MSB
    opd_a = '0; opd_b = '0; opd_c = '0;
    opd_a[0] = 1'b1; opd_b[1] = 1'b1; opd_c[2] = 1'b1;
    tt_imm = 8'b0001_0110; wmask = 16'hFFFF; elem_wide = 1'b0; zero_mode = 1'b1;
    exp_v = '0; exp_v[0] = 1'b1; exp_v[1] = 1'b1; exp_v[2] = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk_vec("R1 index order", result, exp_v);

    // R7: reset after data clears outputs
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk_bit("R7 mid reset", out_valid, 1'b0);
    chk_vec("R7 mid reset", result, '0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule